// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Filter

This block receives asynchronous serial frames from a single data line shared by several nodes. Each frame has a low start bit, eight data bits sent least significant bit first, an optional ninth data bit, and a high stop bit. The line is oversampled on a tick from a programmable divider. A fast-select input sets 16 ticks per bit, and 64 ticks per bit when it is low. Each bit value is the majority of three samples taken around the middle of the bit. Accepted frames go into a two-entry receive queue. Each queue entry holds the byte, the ninth bit and a framing-error flag.

On a shared bus, a node runs in 9-bit mode with the address filter on. In that setting only frames whose ninth bit is 1 (address frames) reach the queue. Frames with a ninth bit of 0 are dropped. Once software sees its own address, it turns the filter off and takes the data frames that follow. The host reads the head entry's ninth bit and error flag together with the byte, and removes the entry with a one-cycle read strobe.

The receiver is a four-state machine:
- **IDLE** waits for a falling edge on the synchronised line (transition *start_seen*).
- **START** checks the mid-bit vote. A high vote is *glitch_reject* back to IDLE. At the end of the bit it takes *start_ok* to DATA.
- **DATA** shifts in 8 or 9 bits and takes *last_bit* to STOP.
- **STOP** votes the stop bit, hands the frame over, and returns to IDLE by *frame_done*.
- From any state, *halt* forces IDLE. This happens whenever the port or receive enable is low, or an overrun is pending.

Top module: `uart_addr_rx`

## Requirements
- R1: A frame is a low start bit, then data bits least significant first, then a stop bit. In 8-bit mode (`nine_bit_i`=0) the byte is returned on `rd_data_o` and `rd_bit9_o` reads 0.
- R2: In 9-bit mode (`nine_bit_i`=1) the bit after the eighth data bit is returned on `rd_bit9_o` with its byte.
- R3: One bit lasts (`divisor_i`+1)×16 clocks when `fast_i`=1 and (`divisor_i`+1)×64 clocks when `fast_i`=0.
- R4: With `nine_bit_i`=1 and `addr_det_i`=1, a frame whose ninth bit is 0 is discarded, and `rx_avail_o` stays low. A frame whose ninth bit is 1 is queued.
- R5: With `addr_det_i`=0, every complete frame is queued, whatever its ninth bit.
- R6: A stop bit voted low queues the frame with `rd_ferr_o`=1. A good stop bit gives `rd_ferr_o`=0.
- R7: The queue holds two entries in arrival order. `rx_avail_o` is high while it is not empty, and a cycle with `rd_i`=1 removes the head.
- R8: A frame that is accepted while the queue is full is dropped and sets `overrun_o`. While `overrun_o` is set, no new frame is received. `overrun_o` is cleared only by `rx_en_i`=0 or `port_en_i`=0. Queued entries stay readable.
- R9: `irq_o` is high exactly when `rx_avail_o` and `int_en_i` are both high.
- R10: A low pulse on the line that has ended by mid-bit is not taken as a start bit and queues nothing.
- R11: `port_en_i`=0 empties the queue, clears `overrun_o` and returns the receiver to IDLE.
- R12: `addr_det_i` has no effect while `nine_bit_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idle high |
| port_en_i | input | 1 | Port enable; low clears everything |
| rx_en_i | input | 1 | Receive enable; low clears overrun and halts reception |
| nine_bit_i | input | 1 | 1 selects 9 data bits per frame |
| addr_det_i | input | 1 | 1 enables the address filter in 9-bit mode |
| fast_i | input | 1 | 1 selects 16 ticks per bit, 0 selects 64 |
| divisor_i | input | DIV_W | Clocks per tick minus one |
| int_en_i | input | 1 | Interrupt enable |
| rd_i | input | 1 | Read strobe, removes the head entry |
| rd_data_o | output | 8 | Head entry byte |
| rd_bit9_o | output | 1 | Head entry ninth bit |
| rd_ferr_o | output | 1 | Head entry framing error |
| rx_avail_o | output | 1 | Queue not empty |
| overrun_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Masked receive interrupt |

## Verification
The hardest condition to reach is overrun with its stickiness. It needs the queue full, a third accepted frame, and then a fourth frame arriving while reception is halted. After that the queue is drained and the flag must persist until the receive enable drops. The bench reaches it by pausing its scoreboard reader, sending four frames back to back, and then releasing the reader. It checks that only the first two entries come out, in order, and that the flag clears only on the enable toggle. The glitch case is driven as a low pulse a few clocks long, far shorter than half a bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic       ferr;
        logic       bit9;
        logic [7:0] data;
    } rx_entry_t;

endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [DIV_W-1:0] divisor_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;

    assign tick_o = (cnt_q == divisor_i) && !clr_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/uart_rx_shifter.sv
module uart_rx_shifter
    import uart_rx_pkg::*;
#(
    parameter int OSR_FAST = 16,
    parameter int OSR_SLOW = 64
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run_i,
    input  logic      rx_i,
    input  logic      fast_i,
    input  logic      nine_i,
    input  logic      tick_i,
    output logic      baud_clr_o,
    output logic      frm_valid_o,
    output rx_entry_t frm_o
);

    localparam int SC_W = $clog2(OSR_SLOW);

    rx_state_e       state_q, state_d;
    logic [SC_W-1:0] sc_q, sc_d;
    logic [1:0]      vote_q, vote_d;
    logic [3:0]      bit_q, bit_d;
    logic [8:0]      sh_q, sh_d;
    logic            nine_q, nine_d;
    logic            rx_s1, rx_s2, rx_prev;

    logic [SC_W-1:0] mid, last;
    logic            fall, win, dec, end_bit, bit_val;
    logic [3:0]      last_idx;

    // two-flop synchroniser plus edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_s1   <= 1'b1;
            rx_s2   <= 1'b1;
            rx_prev <= 1'b1;
        end else begin
            rx_s1   <= rx_i;
            rx_s2   <= rx_s1;
            rx_prev <= rx_s2;
        end
    end

    always_comb begin
        mid      = fast_i ? SC_W'(OSR_FAST / 2) : SC_W'(OSR_SLOW / 2);
        last     = fast_i ? SC_W'(OSR_FAST - 1) : SC_W'(OSR_SLOW - 1);
        fall     = rx_prev && !rx_s2;
        win      = tick_i && ((sc_q == mid - 1'b1) || (sc_q == mid) || (sc_q == mid + 1'b1));
        dec      = tick_i && (sc_q == mid + 1'b1);
        end_bit  = tick_i && (sc_q == last);
        bit_val  = (vote_q[1] & vote_q[0]) | (vote_q[1] & rx_s2) | (vote_q[0] & rx_s2);
        last_idx = nine_q ? 4'd8 : 4'd7;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sc_q    <= '0;
            vote_q  <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            nine_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            sc_q    <= sc_d;
            vote_q  <= vote_d;
            bit_q   <= bit_d;
            sh_q    <= sh_d;
            nine_q  <= nine_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        sc_d        = sc_q;
        vote_d      = vote_q;
        bit_d       = bit_q;
        sh_d        = sh_q;
        nine_d      = nine_q;
        baud_clr_o  = 1'b0;
        frm_valid_o = 1'b0;
        frm_o.ferr  = 1'b0;
        frm_o.bit9  = nine_q ? sh_q[8] : 1'b0;
        frm_o.data  = nine_q ? sh_q[7:0] : sh_q[8:1];

        if (!run_i) begin
            state_d = ST_IDLE;
            sc_d    = '0;
        end else begin
            if (state_q != ST_IDLE) begin
                if (tick_i) begin
                    sc_d = sc_q + 1'b1;
                end
                if (win) begin
                    vote_d = {vote_q[0], rx_s2};
                end
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (fall) begin
                        state_d    = ST_START;
                        sc_d       = '0;
                        nine_d     = nine_i;
                        baud_clr_o = 1'b1;
                    end
                end
                ST_START: begin
                    if (dec && bit_val) begin
                        state_d = ST_IDLE;
                        sc_d    = '0;
                    end else if (end_bit) begin
                        state_d = ST_DATA;
                        sc_d    = '0;
                        bit_d   = '0;
                    end
                end
                ST_DATA: begin
                    if (dec) begin
                        sh_d = {bit_val, sh_q[8:1]};
                    end
                    if (end_bit) begin
                        sc_d = '0;
                        if (bit_q == last_idx) begin
                            state_d = ST_STOP;
                        end else begin
                            bit_d = bit_q + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (dec) begin
                        frm_valid_o = 1'b1;
                        frm_o.ferr  = !bit_val;
                        state_d     = ST_IDLE;
                        sc_d        = '0;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr_i,
    input  logic                       push_i,
    input  rx_entry_t                  din_i,
    input  logic                       pop_i,
    output rx_entry_t                  head_o,
    output logic                       full_o,
    output logic [$clog2(DEPTH+1)-1:0] cnt_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    rx_entry_t        mem_q [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign do_pop  = pop_i && (cnt_q != '0);
    assign do_push = push_i && ((cnt_q != CNT_W'(DEPTH)) || do_pop);
    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign cnt_o   = cnt_q;
    assign head_o  = (cnt_q != '0) ? mem_q[rp_q] : '0;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (clr_i) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= nxt(wp_q);
            if (do_pop)  rp_q <= nxt(rp_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (do_push && !clr_i && (wp_q == PTR_W'(g))) begin
                mem_q[g] <= din_i;
            end
        end
    end

endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
    import uart_rx_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int DEPTH    = 2,
    parameter int OSR_FAST = 16,
    parameter int OSR_SLOW = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_i,
    input  logic             port_en_i,
    input  logic             rx_en_i,
    input  logic             nine_bit_i,
    input  logic             addr_det_i,
    input  logic             fast_i,
    input  logic [DIV_W-1:0] divisor_i,
    input  logic             int_en_i,
    input  logic             rd_i,
    output logic [7:0]       rd_data_o,
    output logic             rd_bit9_o,
    output logic             rd_ferr_o,
    output logic             rx_avail_o,
    output logic             overrun_o,
    output logic             irq_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             tick, baud_clr, run;
    logic             frm_valid, accept, push_s, pop_s, full;
    rx_entry_t        frm, head;
    logic             ovr_q;
    logic [CNT_W-1:0] fifo_cnt;

    assign run = port_en_i && rx_en_i && !ovr_q;

    uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (baud_clr || !port_en_i),
        .divisor_i (divisor_i),
        .tick_o    (tick)
    );

    uart_rx_shifter #(.OSR_FAST(OSR_FAST), .OSR_SLOW(OSR_SLOW)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .rx_i        (rx_i),
        .fast_i      (fast_i),
        .nine_i      (nine_bit_i),
        .tick_i      (tick),
        .baud_clr_o  (baud_clr),
        .frm_valid_o (frm_valid),
        .frm_o       (frm)
    );

    // address filter: only frames with ninth bit set pass in filtered 9-bit mode
    assign accept = frm_valid && (!(nine_bit_i && addr_det_i) || frm.bit9);
    assign pop_s  = rd_i && rx_avail_o;
    assign push_s = accept && (!full || pop_s);

    uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!port_en_i),
        .push_i (push_s),
        .din_i  (frm),
        .pop_i  (pop_s),
        .head_o (head),
        .full_o (full),
        .cnt_o  (fifo_cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (!port_en_i || !rx_en_i) begin
            ovr_q <= 1'b0;
        end else if (accept && full && !pop_s) begin
            ovr_q <= 1'b1;
        end
    end

    assign rx_avail_o = (fifo_cnt != '0);
    assign rd_data_o  = head.data;
    assign rd_bit9_o  = head.bit9;
    assign rd_ferr_o  = head.ferr;
    assign overrun_o  = ovr_q;
    assign irq_o      = rx_avail_o && int_en_i;

endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk #(
    parameter int DEPTH = 2,
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             port_en_i,
    input logic             rx_en_i,
    input logic             nine_bit_i,
    input logic             addr_det_i,
    input logic             rd_i,
    input logic             rd_bit9_o,
    input logic             rx_avail_o,
    input logic             overrun_o,
    input logic             irq_o,
    input logic [CNT_W-1:0] fifo_cnt
);

    AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_avail_o |-> !irq_o); // R9

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH)); // R7

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && rx_en_i && port_en_i) |=> overrun_o); // R8

    AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_o) |-> (fifo_cnt == CNT_W'(DEPTH))); // R8

    AST_OVR_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && !rd_i) |=> (fifo_cnt <= $past(fifo_cnt))); // R8

    AST_PORT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en_i |=> (!rx_avail_o && !overrun_o)); // R11

    AST_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_avail_o) && $past(nine_bit_i && addr_det_i)) |-> rd_bit9_o); // R4

endmodule

bind uart_addr_rx uart_addr_rx_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_en_i  (port_en_i),
    .rx_en_i    (rx_en_i),
    .nine_bit_i (nine_bit_i),
    .addr_det_i (addr_det_i),
    .rd_i       (rd_i),
    .rd_bit9_o  (rd_bit9_o),
    .rx_avail_o (rx_avail_o),
    .overrun_o  (overrun_o),
    .irq_o      (irq_o),
    .fifo_cnt   (fifo_cnt)
);

// File: tb/uart_addr_rx_tb.sv
`timescale 1ns/1ps
module uart_addr_rx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_i = 1'b1;
    logic       port_en_i = 1'b1, rx_en_i = 1'b1, nine_bit_i = 1'b0, addr_det_i = 1'b0;
    logic       fast_i = 1'b1, int_en_i = 1'b0, rd_i = 1'b0;
    logic [7:0] divisor_i = 8'd1;
    logic [7:0] rd_data_o;
    logic       rd_bit9_o, rd_ferr_o, rx_avail_o, overrun_o, irq_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  hold = 1'b0;
    logic [9:0] exp_q[$];

    always #2.5 clk = ~clk;

    uart_addr_rx u_dut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .port_en_i(port_en_i),
        .rx_en_i(rx_en_i), .nine_bit_i(nine_bit_i), .addr_det_i(addr_det_i),
        .fast_i(fast_i), .divisor_i(divisor_i), .int_en_i(int_en_i), .rd_i(rd_i),
        .rd_data_o(rd_data_o), .rd_bit9_o(rd_bit9_o), .rd_ferr_o(rd_ferr_o),
        .rx_avail_o(rx_avail_o), .overrun_o(overrun_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic expect_entry(input logic [7:0] d, input logic b9, input logic fe);
        exp_q.push_back({fe, b9, d});
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic b9, input logic stop_v);
        int bt;
        bt = (int'(divisor_i) + 1) * (fast_i ? 16 : 64);
        rx_i = 1'b0;
        wait_clks(bt);
        for (int i = 0; i < 8; i++) begin
            rx_i = d[i];
            wait_clks(bt);
        end
        if (nine_bit_i) begin
            rx_i = b9;
            wait_clks(bt);
        end
        rx_i = stop_v;
        wait_clks(bt);
        rx_i = 1'b1;
        wait_clks(bt);
    endtask

    task automatic drain(input string req);
        int k;
        k = 0;
        while ((exp_q.size() != 0 || rx_avail_o) && k < 4000) begin
            wait_clks(1);
            k++;
        end
        check(req, exp_q.size(), 0);
    endtask

    // monitor side of the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            rd_i = 1'b0;
            if (rst_n && !hold && rx_avail_o) begin
                if (exp_q.size() == 0) begin
                    check("R7 unexpected entry", {rd_ferr_o, rd_bit9_o, rd_data_o}, 32'h3ff);
                end else begin
                    check("R1 R2 R6 R7 entry", {rd_ferr_o, rd_bit9_o, rd_data_o}, exp_q.pop_front());
                end
                rd_i = 1'b1;
            end
        end
    end

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_clks(8);
        rst_n = 1'b1;
        wait_clks(4);
        // reset state
        check("R7 reset avail", rx_avail_o, 0);
        check("R8 reset overrun", overrun_o, 0);
        check("R9 reset irq", irq_o, 0);

        // R1: 8-bit frames
        expect_entry(8'hA5, 0, 0); send(8'hA5, 0, 1);
        expect_entry(8'h3C, 0, 0); send(8'h3C, 0, 1);
        drain("R1 drain");

        // R3: slow oversampling with different divisors
        fast_i = 1'b0; divisor_i = 8'd0;
        expect_entry(8'h96, 0, 0); send(8'h96, 0, 1);
        divisor_i = 8'd2;
        expect_entry(8'h5A, 0, 0); send(8'h5A, 0, 1);
        fast_i = 1'b1; divisor_i = 8'd3;
        expect_entry(8'hC1, 0, 0); send(8'hC1, 0, 1);
        divisor_i = 8'd1;
        drain("R3 drain");

        // R2 R5: 9-bit mode without filter
        nine_bit_i = 1'b1;
        expect_entry(8'h11, 0, 0); send(8'h11, 0, 1);
        expect_entry(8'h22, 1, 0); send(8'h22, 1, 1);
        drain("R2 R5 drain");

        // R4: filter on
        addr_det_i = 1'b1;
        send(8'h33, 0, 1);
        check("R4 data frame discarded", rx_avail_o, 0);
        expect_entry(8'h44, 1, 0); send(8'h44, 1, 1);
        drain("R4 drain");

        // R12: filter ignored in 8-bit mode
        nine_bit_i = 1'b0;
        expect_entry(8'h55, 0, 0); send(8'h55, 0, 1);
        drain("R12 drain");
        addr_det_i = 1'b0;

        // R6: framing error
        expect_entry(8'h0F, 0, 1); send(8'h0F, 0, 0);
        expect_entry(8'h81, 0, 0); send(8'h81, 0, 1);
        drain("R6 drain");

        // R7 R8 R9: fill, overrun, mask
        hold = 1'b1;
        expect_entry(8'h01, 0, 0); send(8'h01, 0, 1);
        expect_entry(8'h02, 0, 0); send(8'h02, 0, 1);
        check("R7 avail when full", rx_avail_o, 1);
        check("R7 two entries fit", overrun_o, 0);
        check("R9 irq masked", irq_o, 0);
        int_en_i = 1'b1;
        wait_clks(1);
        check("R9 irq enabled", irq_o, 1);
        send(8'h03, 0, 1);
        check("R8 overrun set", overrun_o, 1);
        send(8'h04, 0, 1);
        check("R8 overrun held", overrun_o, 1);
        hold = 1'b0;
        drain("R8 R7 order drain");
        check("R8 sticky after drain", overrun_o, 1);
        check("R8 nothing loaded while overrun", rx_avail_o, 0);
        check("R9 irq low when empty", irq_o, 0);
        rx_en_i = 1'b0;
        wait_clks(2);
        check("R8 cleared by rx_en", overrun_o, 0);
        rx_en_i = 1'b1;
        int_en_i = 1'b0;
        expect_entry(8'h77, 0, 0); send(8'h77, 0, 1);
        drain("R8 recovery drain");

        // R10: glitch rejected
        rx_i = 1'b0; wait_clks(4); rx_i = 1'b1;
        wait_clks(200);
        check("R10 glitch ignored", rx_avail_o, 0);
        expect_entry(8'hC3, 0, 0); send(8'hC3, 0, 1);
        drain("R10 drain");

        // R11: port disable clears queue
        hold = 1'b1;
        send(8'h99, 0, 1);
        check("R11 entry present", rx_avail_o, 1);
        port_en_i = 1'b0;
        wait_clks(2);
        check("R11 queue cleared", rx_avail_o, 0);
        check("R11 overrun clear", overrun_o, 0);
        port_en_i = 1'b1;
        hold = 1'b0;
        expect_entry(8'h6E, 0, 0); send(8'h6E, 0, 1);
        drain("R11 drain");

        finish_run();
    end

endmodule